// File: doc/BRIEF.md
# Multiframe Sync Pulse Position Locator

This block tracks where the system-side receive bus currently is within its multiframe. It keeps a bit counter (eight bits per time slot), a time-slot counter and a frame counter, all advancing once per clock. The frame length (in slots) and the number of frames per multiframe are parameters, and the counters wrap at those limits.

Three programmed fields set where the sync pulses sit: a 3-bit bit offset, a 7-bit time-slot offset and a 5-bit frame offset. The slot and bit offsets together form a 10-bit frame-level position. The frame offset on top of that forms a 15-bit multiframe-level position. A bit offset of 0 means bit 1 of the slot, so an all-zero setting places both pulses on bit 1 of time slot 0.

In generate mode the block raises a frame sync pulse each frame and a multiframe sync pulse once per multiframe, at the programmed position. In accept mode it takes external sync pulses and reloads its counters from the same programmed position, so that its internal view of the bus realigns to the external reference. One offset setting therefore serves both directions.

Top module: `mfsync_locator`

## Requirements
- R1: While `rst` is high both sync outputs are low. After the first clock edge with `rst` high, the position outputs read bit 0, slot 0, frame 0.
- R2: With no load, each clock advances the bit count 0..7. It steps the slot after bit 7 and wraps the slot from SLOTS-1 to 0. It steps the frame on that slot wrap and wraps the frame from FRAMES-1 to 0.
- R3: In generate mode (`accept_mode` = 0) with a valid slot offset, `fsync_out` is high exactly in the cycles where `pos_bit` equals `bit_off` and `pos_slot` equals `slot_off`. The 10-bit frame position is {slot_off, bit_off}, and bit_off = 0 selects bit 1 of the slot.
- R4: In generate mode with both offsets valid, `msync_out` is high exactly when the R3 condition holds and `pos_frame` equals `frm_off`. The 15-bit position is {frm_off, slot_off, bit_off}. `msync_out` is never high without `fsync_out`.
- R5: In accept mode both sync outputs stay low.
- R6: In accept mode, `fsync_in` sampled high at a clock edge (with `msync_in` not taking effect) sets the position to the successor of (current frame, slot_off, bit_off). The frame therefore only steps if that point is the last bit of a frame.
- R7: In accept mode, `msync_in` sampled high with both offsets valid sets the position to the successor of (frm_off, slot_off, bit_off). It has priority over `fsync_in`.
- R8: In generate mode, `fsync_in` and `msync_in` have no effect on the position.
- R9: An offset is valid only if slot_off < SLOTS; the frame part is valid only if frm_off < FRAMES as well. If slot_off is out of range, no sync output pulses and both sync inputs are ignored. If only frm_off is out of range, `msync_out` stays low and `msync_in` is ignored, while `fsync_in` still loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst | input | 1 | Synchronous active-high reset |
| accept_mode | input | 1 | 0: generate sync pulses, 1: accept external sync pulses |
| bit_off | input | 3 | Bit offset within the slot (0 = bit 1) |
| slot_off | input | 7 | Time-slot offset within the frame |
| frm_off | input | 5 | Frame offset within the multiframe |
| fsync_in | input | 1 | External frame sync pulse (accept mode) |
| msync_in | input | 1 | External multiframe sync pulse (accept mode) |
| fsync_out | output | 1 | Generated frame sync pulse |
| msync_out | output | 1 | Generated multiframe sync pulse |
| pos_bit | output | 3 | Current bit position in the slot |
| pos_slot | output | 7 | Current slot position in the frame |
| pos_frame | output | 5 | Current frame position in the multiframe |

## Verification
The sync outputs are combinational on the registered position, so they are due in the same cycle as the position they match. The bench samples them one time unit after the falling edge at which inputs were driven. Loads and counter steps are due at the next rising edge. The bench advances its reference position right after that edge and compares `pos_*` in the following cycle's sample window. Random offsets, modes and pulses are mixed with directed cases for simultaneous pulses, a load at the last bit of the multiframe and out-of-range offsets.

// File: rtl/mfsync_pkg.sv
package mfsync_pkg;

    localparam int BIT_W  = 3;
    localparam int SLOT_W = 7;
    localparam int FRM_W  = 5;
    localparam int FOFF_W = SLOT_W + BIT_W;
    localparam int MOFF_W = FRM_W + FOFF_W;

    // Packed in multiframe order so the struct is itself the 15-bit position
    typedef struct packed {
        logic [FRM_W-1:0]  frame;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } pos_t;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_FRAME = 2'd1,
        LD_MULTI = 2'd2
    } load_e;

    // Position one bit later, wrapping at the configured frame and multiframe size
    function automatic pos_t pos_succ(pos_t p, int unsigned slots, int unsigned frames);
        pos_t n;
        n = p;
        if (p.bitn != {BIT_W{1'b1}}) begin
            n.bitn = p.bitn + 1'b1;
        end else begin
            n.bitn = '0;
            if (32'(p.slot) >= slots - 1) begin
                n.slot = '0;
                if (32'(p.frame) >= frames - 1) begin
                    n.frame = '0;
                end else begin
                    n.frame = p.frame + 1'b1;
                end
            end else begin
                n.slot = p.slot + 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/mfsync_offset_compose.sv
module mfsync_offset_compose
    import mfsync_pkg::*;
#(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned FRAMES = 16
) (
    input  logic [BIT_W-1:0]  bit_off,
    input  logic [SLOT_W-1:0] slot_off,
    input  logic [FRM_W-1:0]  frm_off,
    output logic [FOFF_W-1:0] frame_off,
    output pos_t              multi_off,
    output logic              fs_valid,
    output logic              ms_valid
);

    always_comb begin
        frame_off       = {slot_off, bit_off};
        multi_off       = pos_t'({frm_off, frame_off});
        fs_valid        = 32'(slot_off) < SLOTS;
        ms_valid        = fs_valid && (32'(frm_off) < FRAMES);
    end

endmodule

// File: rtl/mfsync_sync_match.sv
module mfsync_sync_match
    import mfsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_mode,
    input  pos_t              pos,
    input  logic [FOFF_W-1:0] frame_off,
    input  pos_t              multi_off,
    input  logic              fs_valid,
    input  logic              ms_valid,
    input  logic              fsync_i,
    input  logic              msync_i,
    output logic              fsync_o,
    output logic              msync_o,
    output load_e             load_kind,
    output pos_t              load_pos
);

    logic fs_hit;
    logic ms_hit;
    logic gen_en;

    always_comb begin
        fs_hit  = fs_valid && ({pos.slot, pos.bitn} == frame_off);
        ms_hit  = fs_hit && ms_valid && (pos.frame == multi_off.frame);
        gen_en  = !rst && !accept_mode;
        fsync_o = gen_en && fs_hit;
        msync_o = gen_en && ms_hit;
    end

    always_comb begin
        load_kind = LD_NONE;
        load_pos  = pos;
        if (!rst && accept_mode) begin
            if (msync_i && ms_valid) begin
                load_kind = LD_MULTI;
                load_pos  = multi_off;
            end else if (fsync_i && fs_valid) begin
                load_kind = LD_FRAME;
                load_pos  = pos_t'({pos.frame, frame_off});
            end
        end
    end

    // R4: multiframe pulse only ever rides on a frame pulse
    a_r4_multi_within_frame: assert property (@(posedge clk) disable iff (rst)
        msync_o |-> fsync_o);

    // R5: accept mode keeps both outputs silent
    a_r5_quiet_in_accept: assert property (@(posedge clk) disable iff (rst)
        accept_mode |-> (!fsync_o && !msync_o));

    // R8: generate mode never reloads the counters
    a_r8_no_load_generate: assert property (@(posedge clk) disable iff (rst)
        !accept_mode |-> (load_kind == LD_NONE));

    // R9: out-of-range slot offset produces no pulses and no loads
    a_r9_invalid_silent: assert property (@(posedge clk) disable iff (rst)
        !fs_valid |-> (!fsync_o && !msync_o && load_kind == LD_NONE));

endmodule

// File: rtl/mfsync_pos_counter.sv
module mfsync_pos_counter
    import mfsync_pkg::*;
#(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned FRAMES = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  load_e load_kind,
    input  pos_t  load_pos,
    output pos_t  pos
);

    pos_t base;
    pos_t pos_nxt;

    always_comb begin
        base    = (load_kind == LD_NONE) ? pos : load_pos;
        pos_nxt = pos_succ(base, SLOTS, FRAMES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            pos <= pos_nxt;
        end
    end

    // R2: slot and frame counts stay inside their configured range
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        (32'(pos.slot) < SLOTS) && (32'(pos.frame) < FRAMES));

    // R2: without a load the bit count moves forward by one
    a_r2_bit_steps: assert property (@(posedge clk) disable iff (rst)
        (load_kind == LD_NONE) |=> (pos.bitn == $past(pos.bitn) + 3'd1));

    // R6/R7: after a load the bit count sits one past the loaded bit
    a_r7_load_lands: assert property (@(posedge clk) disable iff (rst)
        (load_kind != LD_NONE) |=> (pos.bitn == $past(load_pos.bitn) + 3'd1));

endmodule

// File: rtl/mfsync_locator.sv
module mfsync_locator
    import mfsync_pkg::*;
#(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned FRAMES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_mode,
    input  logic [BIT_W-1:0]  bit_off,
    input  logic [SLOT_W-1:0] slot_off,
    input  logic [FRM_W-1:0]  frm_off,
    input  logic              fsync_in,
    input  logic              msync_in,
    output logic              fsync_out,
    output logic              msync_out,
    output logic [BIT_W-1:0]  pos_bit,
    output logic [SLOT_W-1:0] pos_slot,
    output logic [FRM_W-1:0]  pos_frame
);

    logic [FOFF_W-1:0] frame_off;
    pos_t              multi_off;
    logic              fs_valid;
    logic              ms_valid;
    pos_t              pos;
    load_e             load_kind;
    pos_t              load_pos;

    mfsync_offset_compose #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_compose (
        .bit_off   (bit_off),
        .slot_off  (slot_off),
        .frm_off   (frm_off),
        .frame_off (frame_off),
        .multi_off (multi_off),
        .fs_valid  (fs_valid),
        .ms_valid  (ms_valid)
    );

    mfsync_sync_match u_match (
        .clk         (clk),
        .rst         (rst),
        .accept_mode (accept_mode),
        .pos         (pos),
        .frame_off   (frame_off),
        .multi_off   (multi_off),
        .fs_valid    (fs_valid),
        .ms_valid    (ms_valid),
        .fsync_i     (fsync_in),
        .msync_i     (msync_in),
        .fsync_o     (fsync_out),
        .msync_o     (msync_out),
        .load_kind   (load_kind),
        .load_pos    (load_pos)
    );

    mfsync_pos_counter #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load_kind (load_kind),
        .load_pos  (load_pos),
        .pos       (pos)
    );

    assign pos_bit   = pos.bitn;
    assign pos_slot  = pos.slot;
    assign pos_frame = pos.frame;

    // R1: no pulse leaves the block during reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> (!fsync_out && !msync_out));

endmodule

// File: tb/mfsync_locator_tb.sv
module mfsync_locator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 5;
    localparam int FRAMES     = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       accept_mode;
    logic [2:0] bit_off;
    logic [6:0] slot_off;
    logic [4:0] frm_off;
    logic       fsync_in;
    logic       msync_in;
    logic       fsync_out;
    logic       msync_out;
    logic [2:0] pos_bit;
    logic [6:0] pos_slot;
    logic [4:0] pos_frame;

    int checks = 0;
    int errors = 0;
    int mb = 0, ms = 0, mf = 0;
    bit model_known = 1'b0;
    string pos_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mfsync_locator #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_dut (
        .clk(clk), .rst(rst), .accept_mode(accept_mode),
        .bit_off(bit_off), .slot_off(slot_off), .frm_off(frm_off),
        .fsync_in(fsync_in), .msync_in(msync_in),
        .fsync_out(fsync_out), .msync_out(msync_out),
        .pos_bit(pos_bit), .pos_slot(pos_slot), .pos_frame(pos_frame)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic succ(inout int b, inout int s, inout int f);
        if (b < 7) b++;
        else begin
            b = 0;
            if (s < SLOTS - 1) s++;
            else begin
                s = 0;
                f = (f < FRAMES - 1) ? f + 1 : 0;
            end
        end
    endtask

    task automatic step(input bit r, input bit m, input int bo, input int so, input int fo,
                        input bit fi, input bit mi);
        bit fsv, msv, fexp, mexp;
        int nb, ns, nf;
        @(negedge clk);
        rst = r; accept_mode = m;
        bit_off = 3'(bo); slot_off = 7'(so); frm_off = 5'(fo);
        fsync_in = fi; msync_in = mi;
        #1;
        fsv  = so < SLOTS;
        msv  = fsv && (fo < FRAMES);
        if (!r && model_known) begin
            chk(pos_req, "pos_bit", int'(pos_bit), mb);
            chk(pos_req, "pos_slot", int'(pos_slot), ms);
            chk(pos_req, "pos_frame", int'(pos_frame), mf);
        end
        fexp = !r && !m && fsv && model_known && mb == bo && ms == so;
        mexp = fexp && msv && mf == fo;
        if (r || model_known) begin
            chk(r ? "R1" : (m ? "R5" : (fsv ? "R3" : "R9")), "fsync_out", int'(fsync_out), int'(fexp));
            chk(r ? "R1" : (m ? "R5" : (msv ? "R4" : "R9")), "msync_out", int'(msync_out), int'(mexp));
        end
        @(posedge clk);
        if (r) begin
            mb = 0; ms = 0; mf = 0; model_known = 1'b1; pos_req = "R1";
        end else if (m && mi && msv) begin
            nb = bo; ns = so; nf = fo; succ(nb, ns, nf);
            mb = nb; ms = ns; mf = nf; pos_req = "R7";
        end else if (m && fi && fsv) begin
            nb = bo; ns = so; nf = mf; succ(nb, ns, nf);
            mb = nb; ms = ns; mf = nf; pos_req = "R6";
        end else begin
            succ(mb, ms, mf);
            pos_req = (fi || mi) ? (m ? "R9" : "R8") : "R2";
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1'b1; accept_mode = 1'b0; bit_off = '0; slot_off = '0; frm_off = '0;
        fsync_in = 1'b0; msync_in = 1'b0;
        // R1: reset with offset zero must still keep outputs low
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0);
        // R3/R4: zero offset pulses on bit 1 of slot 0, frame 0; run two multiframes
        for (int i = 0; i < 2 * SLOTS * 8 * FRAMES; i++) step(0, 0, 0, 0, 0, 0, 0);
        // R3/R4: last bit of the multiframe
        for (int i = 0; i < SLOTS * 8 * FRAMES + 3; i++) step(0, 0, 7, SLOTS-1, FRAMES-1, 0, 0);
        // R8: pulses in generate mode leave the count alone
        for (int i = 0; i < 20; i++) step(0, 0, 2, 1, 1, 1, i[0]);
        // R7: both pulses at once, load at last bit wraps the whole multiframe
        step(0, 1, 7, SLOTS-1, FRAMES-1, 1, 1);
        step(0, 1, 7, SLOTS-1, FRAMES-1, 0, 0);
        // R6: frame pulse at last bit of a frame steps the frame count
        step(0, 1, 7, SLOTS-1, 0, 1, 0);
        step(0, 1, 3, 2, 1, 0, 0);
        // R9: slot offset out of range, both pulses ignored
        for (int i = 0; i < 5; i++) step(0, 1, 1, SLOTS+1, 0, 1, 1);
        for (int i = 0; i < 50; i++) step(0, 0, 1, SLOTS, 0, 0, 0);
        // R9: frame offset out of range, msync ignored but fsync loads
        step(0, 1, 4, 2, FRAMES, 1, 1);
        step(0, 1, 4, 2, FRAMES, 0, 1);
        step(0, 1, 4, 2, FRAMES, 0, 0);
        for (int i = 0; i < 200; i++) step(0, 0, 4, 2, FRAMES, 0, 0);
        // Mixed random traffic
        begin
            int bo = 0, so = 0, fo = 0;
            bit m = 1'b0;
            for (int i = 0; i < 6000; i++) begin
                if ($urandom % 60 == 0) begin
                    bo = $urandom % 8; so = $urandom % 7; fo = $urandom % 4;
                end
                if ($urandom % 300 == 0) m = ~m;
                step(($urandom % 2000) == 0, m, bo, so, fo,
                     ($urandom % 25) == 0, ($urandom % 50) == 0);
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule